// File: doc/BRIEF.md
# Serial Flash Write-Unit Shifter

This block sends one write-only unit of 8, 16 or 32 bits to a single-lane serial flash device. Software programs a transmit word, a length code, the timing fields, the bit-rate divider and the clock mode through a small word-addressed register port. It then writes the control word with both the go bit and the write-enable bit set. The engine asserts the active-low select, waits a lead delay, shifts the unit out and leaves the select asserted or releases it. A released select is followed by a negate delay and an idle gap.

A keep-select bit captured at start lets software chain several units into one flash command. After such a unit the engine parks in a holding state with the select still low, and the next start shifts at once without a lead delay. A status bit tells software when the engine can take the next unit.

The controller is one state machine with six states. IDLE waits for a start. LEAD is the select-to-clock delay. SHIFT drives the serial clock and data. TAIL is the delay before the select is released. GAP is the idle time after release. HOLD keeps the select asserted between chained units. The transitions are: IDLE→LEAD on an accepted start; LEAD→SHIFT when the lead count expires; SHIFT→TAIL after the last bit when keep-select is clear; SHIFT→HOLD after the last bit when keep-select is set; TAIL→GAP when the negate count expires; GAP→IDLE when the idle count expires; HOLD→SHIFT on an accepted start.

Register word addresses: 0 control (bit 0 go, bit 1 write-enable, bit 2 keep-select), 1 transmit word, 2 length code in bits 3:0, 3 timing (lead in bits 2:0, negate in bits 6:4, idle in bits 10:8), 4 bit-rate divider in bits 7:0, 5 mode (bit 0 polarity, bit 1 transmit phase), 6 status (bit 0 transfer end).

Top module: `sfx_engine`

## Requirements
- R1: After reset the select is high, the serial clock and data lines are 0, the status bit reads 1, the divider reads 1, the mode reads 0 and the control word reads 0.
- R2: A write to the control word with bit 0 (go) and bit 1 (write-enable) both set starts a unit when the engine is in IDLE or HOLD. Go and write-enable read back as 0, and bit 2 reads back as the last keep-select value written.
- R3: Length code 0x8 sends 8 bits, 0xC sends 16 bits and 0xF sends 32 bits. With any other code a start is ignored: the select stays high and the status stays 1.
- R4: Each byte is sent most significant bit first, and the bytes go out from the lowest byte upward: bits 7:0, then 15:8, 23:16 and 31:24.
- R5: The select asserts, and lead+1 clock cycles later SHIFT begins. In mode 0 the first rising clock edge follows that by one half period.
- R6: After the last clock edge of an unsent-keep unit, the select rises after negate+1 cycles, and the status bit returns to 1 idle+1 cycles after that.
- R7: Each half period of the serial clock lasts the divider value in cycles, and a divider of 0 acts as 1.
- R8: The serial clock idles at the polarity bit. With transmit phase 0 the data is sampled on the leading edge, and with transmit phase 1 on the trailing edge.
- R9: With keep-select set at start, the select stays low after the unit and the status reads 1. The next unit follows with no further select assertion.
- R10: The status bit reads 0 from the cycle after an accepted start until the unit completes.
- R11: A start written while a unit is in progress is ignored. The active unit carries on unchanged and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| flash_cs_n | output | 1 | Active-low flash select |
| flash_sck | output | 1 | Serial clock |
| flash_mosi | output | 1 | Serial data to the flash |

## Verification
The assertions assume that the divider, mode and timing registers are only rewritten while the select is high. A live change could leave the half-period counter beyond its new limit, or bend a clock edge. The stimulus therefore reprograms those fields only after the status has returned to 1 with the select released. During a busy unit it writes only the transmit word and the control word, which must not disturb the unit in flight.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CNT_W  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_TXD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TIME = 3'd3;
    localparam logic [ADDR_W-1:0] A_RATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

    localparam logic [3:0] LEN_8  = 4'h8;
    localparam logic [3:0] LEN_16 = 4'hC;
    localparam logic [3:0] LEN_32 = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL, ST_GAP, ST_HOLD
    } sfx_state_e;

    function automatic logic [CNT_W-1:0] len_bits(input logic [3:0] code);
        case (code)
            LEN_8:   return CNT_W'(8);
            LEN_16:  return CNT_W'(16);
            LEN_32:  return CNT_W'(32);
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_order(input logic [WORD_W-1:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction
endpackage

// File: rtl/sfx_regs.sv
module sfx_regs
    import sfx_pkg::*;
#(
    parameter int unsigned DLY_W = 3,
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              done_i,
    output logic              go_o,
    output logic              go_keep_o,
    output logic [WORD_W-1:0] txd_o,
    output logic [CNT_W-1:0]  nbits_o,
    output logic [DLY_W-1:0]  lead_o,
    output logic [DLY_W-1:0]  neg_o,
    output logic [DLY_W-1:0]  idle_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              cpol_o,
    output logic              cpha_o
);
    localparam int unsigned FLD = 4;

    logic       keep_r;
    logic [3:0] len_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_r <= 1'b0;
            len_r  <= '0;
            txd_o  <= '0;
            lead_o <= '0;
            neg_o  <= '0;
            idle_o <= '0;
            div_o  <= DIV_W'(1);
            cpol_o <= 1'b0;
            cpha_o <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: keep_r <= bus_wdata[2];
                A_TXD:  txd_o  <= bus_wdata;
                A_LEN:  len_r  <= bus_wdata[3:0];
                A_TIME: begin
                    lead_o <= bus_wdata[DLY_W-1:0];
                    neg_o  <= bus_wdata[FLD +: DLY_W];
                    idle_o <= bus_wdata[2*FLD +: DLY_W];
                end
                A_RATE: div_o <= bus_wdata[DIV_W-1:0];
                A_MODE: begin
                    cpol_o <= bus_wdata[0];
                    cpha_o <= bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    assign nbits_o   = len_bits(len_r);
    assign go_o      = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0] && bus_wdata[1]
                       && (nbits_o != '0);
    assign go_keep_o = bus_wdata[2];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata[2] = keep_r;
            A_TXD:  bus_rdata = txd_o;
            A_LEN:  bus_rdata[3:0] = len_r;
            A_TIME: begin
                bus_rdata[DLY_W-1:0]       = lead_o;
                bus_rdata[FLD +: DLY_W]    = neg_o;
                bus_rdata[2*FLD +: DLY_W]  = idle_o;
            end
            A_RATE: bus_rdata[DIV_W-1:0] = div_o;
            A_MODE: bus_rdata[1:0] = {cpha_o, cpol_o};
            A_STAT: bus_rdata[0] = done_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/sfx_baud.sv
module sfx_baud #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? DIV_W'(1) : div;
    assign tick = run && (cnt == lim - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + DIV_W'(1);
    end

    // R7: the half-period counter never passes its limit
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim));
endmodule

// File: rtl/sfx_core.sv
module sfx_core
    import sfx_pkg::*;
#(
    parameter int unsigned DLY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_keep,
    input  logic [WORD_W-1:0] txd,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [DLY_W-1:0]  lead,
    input  logic [DLY_W-1:0]  neg,
    input  logic [DLY_W-1:0]  idle,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    output logic              run,
    output logic              done,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi
);
    sfx_state_e        st, st_nx;
    logic [DLY_W-1:0]  dcnt;
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  bcnt;
    logic              ph;
    logic              keep_l;
    logic              accept;
    logic              last_edge;

    assign accept    = go && (st == ST_IDLE || st == ST_HOLD);
    assign last_edge = (st == ST_SHIFT) && tick && ph && (bcnt == CNT_W'(1));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (accept) st_nx = ST_LEAD;
            ST_LEAD:  if (dcnt == '0) st_nx = ST_SHIFT;
            ST_SHIFT: if (last_edge) st_nx = keep_l ? ST_HOLD : ST_TAIL;
            ST_TAIL:  if (dcnt == '0) st_nx = ST_GAP;
            ST_GAP:   if (dcnt == '0) st_nx = ST_IDLE;
            ST_HOLD:  if (accept) st_nx = ST_SHIFT;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt   <= '0;
            sr     <= '0;
            bcnt   <= '0;
            ph     <= 1'b0;
            keep_l <= 1'b0;
            done   <= 1'b1;
        end else if (accept) begin
            sr     <= lane_order(txd);
            bcnt   <= nbits;
            ph     <= 1'b0;
            keep_l <= go_keep;
            dcnt   <= lead;
            done   <= 1'b0;
        end else begin
            case (st)
                ST_LEAD: if (dcnt != '0) dcnt <= dcnt - 1'b1;
                ST_SHIFT: if (tick) begin
                    ph <= ~ph;
                    if (ph) begin
                        sr   <= {sr[WORD_W-2:0], 1'b0};
                        bcnt <= bcnt - 1'b1;
                        if (bcnt == CNT_W'(1)) begin
                            dcnt <= neg;
                            if (keep_l) done <= 1'b1;
                        end
                    end
                end
                ST_TAIL: dcnt <= (dcnt != '0) ? dcnt - 1'b1 : idle;
                ST_GAP: begin
                    if (dcnt != '0) dcnt <= dcnt - 1'b1;
                    else            done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        run  = (st == ST_SHIFT);
        cs_n = (st == ST_IDLE) || (st == ST_GAP);
        sck  = run ? (cpol ^ cpha ^ ph) : cpol;
        mosi = run & sr[WORD_W-1];
    end

    // R8: clock sits at the polarity level while deselected
    assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cpol));
    // R10: status reads 0 while a unit is in flight
    assert_busy_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {ST_LEAD, ST_SHIFT, ST_TAIL, ST_GAP}) |-> !done);
    // R11: a start during shifting leaves the bit count untouched
    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st == ST_SHIFT && !tick) |=> $stable(bcnt));
    // R9: a kept unit parks with select low and status set
    assert_keep_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_edge && keep_l) |=> (!cs_n && done));
endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
    import sfx_pkg::*;
#(
    parameter int unsigned DLY_W = 3,
    parameter int unsigned DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        flash_cs_n,
    output logic        flash_sck,
    output logic        flash_mosi
);
    logic              go, go_keep, done, tick, run, cpol, cpha;
    logic [WORD_W-1:0] txd;
    logic [CNT_W-1:0]  nbits;
    logic [DLY_W-1:0]  lead, neg, idle;
    logic [DIV_W-1:0]  div;

    sfx_regs #(.DLY_W(DLY_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_i(done),
        .go_o(go), .go_keep_o(go_keep), .txd_o(txd), .nbits_o(nbits),
        .lead_o(lead), .neg_o(neg), .idle_o(idle), .div_o(div),
        .cpol_o(cpol), .cpha_o(cpha)
    );

    sfx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
    );

    sfx_core #(.DLY_W(DLY_W)) u_core (
        .clk(clk), .rst_n(rst_n), .go(go), .go_keep(go_keep), .txd(txd),
        .nbits(nbits), .lead(lead), .neg(neg), .idle(idle), .tick(tick),
        .cpol(cpol), .cpha(cpha), .run(run), .done(done),
        .cs_n(flash_cs_n), .sck(flash_sck), .mosi(flash_mosi)
    );

    // R3: a start with an unknown length code never asserts the select
    assert_bad_code_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[1:0] == 2'b11 && nbits == '0
         && flash_cs_n) |=> flash_cs_n);
endmodule

// File: tb/sim_sfx_engine.sv
module sim_sfx_engine;
    typedef struct packed {
        logic [3:0]  code;
        logic [31:0] data;
        logic [1:0]  mode;
        logic [7:0]  div;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'hF, 32'hA5C3_1E7B, 2'd0, 8'd1},
        '{4'hC, 32'h0000_B24D, 2'd1, 8'd2},
        '{4'h8, 32'h0000_0081, 2'd2, 8'd1},
        '{4'hF, 32'h1234_5678, 2'd3, 8'd2},
        '{4'hC, 32'hFFFF_00FF, 2'd0, 8'd4},
        '{4'h8, 32'h0000_005A, 2'd0, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd6;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flash_cs_n, flash_sck, flash_mosi;

    always #4 clk = ~clk;

    sfx_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_cs_n(flash_cs_n),
        .flash_sck(flash_sck), .flash_mosi(flash_mosi)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // port monitor
    int          cyc = 0;
    logic        pcs = 1'b1, psck = 1'b0, pdone = 1'b1;
    logic        m_cpol = 1'b0, m_cpha = 1'b0;
    logic [63:0] cap;
    int nb, edges, cs_falls;
    int t_cs_fall, t_first, t_second, t_last, t_cs_rise, t_done;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (pcs && !flash_cs_n) begin cs_falls <= cs_falls + 1; t_cs_fall <= cyc; end
        if (!pcs && flash_cs_n) t_cs_rise <= cyc;
        if (!flash_cs_n && flash_sck != psck) begin
            if (edges == 0) t_first <= cyc;
            if (edges == 1) t_second <= cyc;
            t_last <= cyc;
            edges <= edges + 1;
            if (flash_sck == (m_cpol ^ ~m_cpha)) begin
                cap <= {cap[62:0], flash_mosi};
                nb  <= nb + 1;
            end
        end
        if (bus_addr == 3'd6) begin
            if (bus_rdata[0] && !pdone) t_done <= cyc;
            pdone <= bus_rdata[0];
        end
        pcs  <= flash_cs_n;
        psck <= flash_sck;
    end

    task automatic clr_mon();
        @(negedge clk);
        cap = '0; nb = 0; edges = 0; cs_falls = 0;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd6;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 3'd6;
    endtask

    task automatic wait_done();
        int n = 0;
        bus_addr = 3'd6;
        while (!bus_rdata[0] && n < 20000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        wr(3'd5, {30'b0, m});
        m_cpol = m[0]; m_cpha = m[1];
    endtask

    function automatic logic [63:0] exp_cap(input logic [3:0] c, input logic [31:0] d);
        case (c)
            4'h8:    return {56'b0, d[7:0]};
            4'hC:    return {48'b0, d[7:0], d[15:8]};
            default: return {32'b0, d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    function automatic int exp_bits(input logic [3:0] c);
        return (c == 4'h8) ? 8 : (c == 4'hC) ? 16 : 32;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(flash_cs_n == 1'b1, "R1 cs_n", flash_cs_n, 1);
        check(flash_sck == 1'b0 && flash_mosi == 1'b0, "R1 sck/mosi", {flash_sck, flash_mosi}, 0);
        rd(3'd6, r); check(r == 32'd1, "R1 status", r, 1);
        rd(3'd4, r); check(r == 32'd1, "R1 divider", r, 1);
        rd(3'd5, r); check(r == 32'd0, "R1 mode", r, 0);
        rd(3'd0, r); check(r == 32'd0, "R1 control", r, 0);

        // vector table: R3 lengths, R4 order, R8 modes
        foreach (VECS[i]) begin
            wr(3'd2, {28'b0, VECS[i].code});
            wr(3'd1, VECS[i].data);
            wr(3'd4, {24'b0, VECS[i].div});
            wr(3'd3, 32'd0);
            set_mode(VECS[i].mode);
            clr_mon();
            wr(3'd0, 32'd3);
            wait_done();
            check(cap == exp_cap(VECS[i].code, VECS[i].data), "R4 R8 data", cap,
                  exp_cap(VECS[i].code, VECS[i].data));
            check(nb == exp_bits(VECS[i].code), "R3 bit count", nb, exp_bits(VECS[i].code));
            check(cs_falls == 1 && flash_cs_n, "R2 one select cycle", cs_falls, 1);
        end

        // R5 R6 timing, mode 0, divider 3
        set_mode(2'd0);
        wr(3'd4, 32'd3);
        wr(3'd3, 32'h0000_0432);
        wr(3'd2, 32'h8);
        wr(3'd1, 32'h0000_00C6);
        clr_mon();
        wr(3'd0, 32'd3);
        rd(3'd6, r); check(r[0] == 1'b0, "R10 status low while busy", r[0], 0);
        wait_done();
        check(t_first - t_cs_fall == 6, "R5 lead to first edge", t_first - t_cs_fall, 6);
        check(t_second - t_first == 3, "R7 half period", t_second - t_first, 3);
        check(t_cs_rise - t_last == 4, "R6 negate delay", t_cs_rise - t_last, 4);
        check(t_done - t_cs_rise == 5, "R6 idle gap", t_done - t_cs_rise, 5);
        check(cap == 64'hC6, "R4 timed data", cap, 64'hC6);

        // R7 divider zero acts as one
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        clr_mon();
        wr(3'd0, 32'd3);
        wait_done();
        check(t_second - t_first == 1, "R7 zero divider", t_second - t_first, 1);
        check(cap == 64'hC6 && nb == 8, "R7 zero divider data", cap, 64'hC6);

        // R9 keep-select chaining
        wr(3'd4, 32'd1);
        wr(3'd1, 32'h0000_003C);
        clr_mon();
        wr(3'd0, 32'd7);
        wait_done();
        check(flash_cs_n == 1'b0, "R9 select held", flash_cs_n, 0);
        rd(3'd6, r); check(r[0] == 1'b1, "R9 status in hold", r[0], 1);
        rd(3'd0, r); check(r == 32'd4, "R2 control readback", r, 4);
        wr(3'd1, 32'h0000_00C1);
        wr(3'd0, 32'd3);
        wait_done();
        check(cap == 64'h3CC1 && nb == 16, "R9 chained data", cap, 64'h3CC1);
        check(cs_falls == 1 && flash_cs_n, "R9 single select", cs_falls, 1);
        rd(3'd0, r); check(r == 32'd0, "R2 self-clearing bits", r, 0);

        // R11 start while busy
        wr(3'd2, 32'hF);
        wr(3'd4, 32'd2);
        wr(3'd1, 32'hDEAD_BEEF);
        clr_mon();
        wr(3'd0, 32'd3);
        repeat (10) @(negedge clk);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'd3);
        rd(3'd6, r); check(r[0] == 1'b0, "R11 status stays low", r[0], 0);
        wait_done();
        check(cap == 64'hEFBE_ADDE && nb == 32, "R11 unit unchanged", cap, 64'hEFBE_ADDE);
        check(cs_falls == 1, "R11 no restart", cs_falls, 1);

        // R3 invalid code ignored
        wr(3'd2, 32'h5);
        clr_mon();
        wr(3'd0, 32'd3);
        repeat (20) @(negedge clk);
        check(cs_falls == 0 && flash_cs_n, "R3 invalid code no select", cs_falls, 0);
        rd(3'd6, r); check(r[0] == 1'b1, "R3 invalid code status", r[0], 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule